// File: doc/BRIEF.md
# Graphics command packet framer

The framer sits between a source of 32-bit graphics command words and the units that act on whole commands. The top byte of the first word of each packet is its opcode. An opcode-indexed length rule, computed rather than stored, gives the total number of words in the packet. The framer collects that many words into a buffer and presents the finished packet on a valid/ready port. Each packet carries a class tag: draw, VRAM-to-VRAM copy, image transfer or environment setting.

While a packet is incomplete, the framer keeps the words it has and emits nothing. It reports that it holds a partial packet and how many words are still missing. Environment opcodes also update eight shadow registers that are visible on a flat output bus. Opcode 0x1F is an anomaly marker that is swallowed. A packet longer than the buffer is discarded, and a sticky flag records the loss.

Top module: `cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word, and the packet length in words is fixed by the opcode. Draw examples: 0x00 and 0x6C are 1 word; 0x68 and 0x70 are 2; 0x02, 0x40, 0x60, 0x74 and 0x7C are 3; 0x20, 0x50 and 0x64 are 4; 0x28 is 5; 0x30 is 6; 0x24 is 7; 0x38 is 8; 0x2C and 0x34 are 9; 0x3C is 12. All draw packets (0x00 to 0x7F) carry class 0, and `pkt_len` gives the word count.
- R2: Opcodes 0x80 to 0x9F form 4-word packets of class 1 (VRAM copy).
- R3: Opcodes 0xA0 to 0xDF form 3-word packets of class 2 (image transfer).
- R4: Opcodes 0xE0 to 0xFF form 1-word packets of class 3 (environment). For an opcode 0xE0 to 0xEF, the whole word is written into shadow slot opcode[2:0], which appears on `shadow_flat` bits [32n+31:32n].
- R5: Until the last word of a packet is accepted, `pkt_valid` stays low, `partial` is 1 and `remain` equals the number of words still missing. Packet word i appears on `pkt_data` bits [32i+31:32i].
- R6: A first word with opcode 0x1F is consumed alone. It produces no packet, changes no shadow slot, and the next word starts a new packet.
- R7: While an opcode 0x02 packet is presented, `fill_w` equals bits 9:0 of its third word and `fill_h` equals bits 24:16 of that word.
- R8: A packet longer than DEPTH words sets the sticky `overflow` flag. All of its words are consumed and dropped, and no packet is emitted. The word after it starts a new packet.
- R9: A presented packet is held stable until `pkt_ready` is seen high. While a packet is held, `in_ready` is low.
- R10: Synchronous reset empties the buffer, clears every shadow slot and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Framer can accept a word |
| pkt_valid | output | 1 | Complete packet presented |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_class | output | 2 | 0 draw, 1 copy, 2 image, 3 environment |
| pkt_len | output | 5 | Packet length in words |
| pkt_data | output | DEPTH*32 | Packet words, word 0 lowest |
| fill_w | output | 10 | Fill width from word 2 |
| fill_h | output | 9 | Fill height from word 2 |
| partial | output | 1 | Incomplete packet held |
| remain | output | 5 | Words still missing |
| overflow | output | 1 | Sticky oversize-packet flag |
| shadow_flat | output | 256 | Eight environment shadow slots |

## Verification
Every result is registered by the edge that accepts a word. `partial`, `remain`, `overflow`, the shadow slots and `pkt_valid` with its fields are all due exactly one edge after the accepting one. `pkt_valid` falls one edge after `pkt_ready` is sampled high. The bench changes inputs only on falling edges and reads outputs on the next falling edge. This puts each check half a cycle after the register that produces the value being checked. A packet that is being held is checked over several idle cycles to show it stays stable.

// File: rtl/cmd_framer.sv
module cmd_framer #(
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [31:0]         in_word,
  output logic                in_ready,
  output logic                pkt_valid,
  input  logic                pkt_ready,
  output logic [1:0]          pkt_class,
  output logic [4:0]          pkt_len,
  output logic [DEPTH*32-1:0] pkt_data,
  output logic [9:0]          fill_w,
  output logic [8:0]          fill_h,
  output logic                partial,
  output logic [4:0]          remain,
  output logic                overflow,
  output logic [255:0]        shadow_flat
);
  localparam int LW  = 5;
  localparam int IW  = $clog2(DEPTH);
  localparam int NSH = 8;

  function automatic logic [LW-1:0] op_len(input logic [7:0] op);
    case (op[7:5])
      3'd0: op_len = (op == 8'h02) ? LW'(3) : LW'(1);
      3'd1: case (op[4:2])
        3'd0: op_len = 4;  3'd1: op_len = 7;
        3'd2: op_len = 5;  3'd3: op_len = 9;
        3'd4: op_len = 6;  3'd5: op_len = 9;
        3'd6: op_len = 8;  default: op_len = 12;
      endcase
      3'd2: op_len = op[4] ? LW'(4) : LW'(3);
      3'd3: case ({op[4], op[3:2]})
        3'b000: op_len = 3;  3'b001: op_len = 4;
        3'b010: op_len = 2;  3'b011: op_len = 1;
        3'b100: op_len = 2;  3'b101: op_len = 3;
        3'b110: op_len = 2;  default: op_len = 3;
      endcase
      3'd4: op_len = 4;
      3'd7: op_len = 1;
      default: op_len = 3;
    endcase
  endfunction

  logic [31:0]   pbuf [DEPTH];
  logic [31:0]   shadow [NSH];
  logic [LW-1:0] cnt, need, skip;
  logic [1:0]    cls;
  logic          full;

  wire [7:0]    op_in  = in_word[31:24];
  wire [LW-1:0] len_in = op_len(op_in);
  wire [1:0]    cls_in = (op_in[7:5] == 3'd4) ? 2'd1 :
                         (op_in[7:5] == 3'd5 || op_in[7:5] == 3'd6) ? 2'd2 :
                         (op_in[7:5] == 3'd7) ? 2'd3 : 2'd0;
  wire          take   = in_valid && in_ready;

  assign in_ready  = !full;
  assign pkt_valid = full;
  assign pkt_class = cls;
  assign pkt_len   = need;
  assign partial   = (cnt != 0);
  assign remain    = partial ? need - cnt : '0;
  assign fill_w    = pbuf[2][9:0];
  assign fill_h    = pbuf[2][24:16];

  for (genvar i = 0; i < DEPTH; i++) begin : g_data
    assign pkt_data[i*32 +: 32] = pbuf[i];
  end
  for (genvar i = 0; i < NSH; i++) begin : g_sh
    assign shadow_flat[i*32 +: 32] = shadow[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; need <= '0; skip <= '0; cls <= '0;
      full <= 1'b0; overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pbuf[i] <= '0;
      for (int i = 0; i < NSH; i++) shadow[i] <= '0;
    end else begin
      if (full && pkt_ready) full <= 1'b0;
      if (take) begin
        if (skip != 0) begin
          skip <= skip - 1'b1;
        end else if (cnt == 0) begin
          if (op_in == 8'h1F) begin
          end else if (len_in > LW'(DEPTH)) begin
            overflow <= 1'b1;
            skip     <= len_in - 1'b1;
          end else begin
            pbuf[0] <= in_word;
            cls     <= cls_in;
            need    <= len_in;
            if (len_in == 1) full <= 1'b1;
            else cnt <= 1;
            if (op_in[7:4] == 4'hE) shadow[op_in[2:0]] <= in_word;
          end
        end else begin
          pbuf[cnt[IW-1:0]] <= in_word;
          if (cnt + 1'b1 == need) begin
            full <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_class) && $stable(pkt_len) && $stable(pkt_data));
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r5_partial: assert property (@(posedge clk) disable iff (rst)
    partial |-> remain != 0 && !pkt_valid);
  a_r2_copy_len: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_class == 2'd1 |-> pkt_len == 4);
  a_r3_image_len: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_class == 2'd2 |-> pkt_len == 3);
  a_r4_env_len: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_class == 2'd3 |-> pkt_len == 1);
  a_r6_anomaly: assert property (@(posedge clk) disable iff (rst)
    take && op_in == 8'h1F && cnt == 0 && skip == 0 |=> !pkt_valid && !partial && $stable(shadow_flat));
  a_r10_reset: assert property (@(posedge clk)
    rst |=> !pkt_valid && !partial && !overflow && shadow_flat == '0);
endmodule

// File: tb/cmd_framer_test.sv
`timescale 1ns/100ps
module cmd_framer_test;
  localparam int DEPTH = 8;
  logic clk = 0, rst = 1, in_valid = 0, pkt_ready = 0;
  logic [31:0] in_word = '0;
  logic in_ready, pkt_valid, partial, overflow;
  logic [1:0] pkt_class;
  logic [4:0] pkt_len, remain;
  logic [DEPTH*32-1:0] pkt_data;
  logic [9:0] fill_w;
  logic [8:0] fill_h;
  logic [255:0] shadow_flat;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cmd_framer #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_class(pkt_class), .pkt_len(pkt_len),
    .pkt_data(pkt_data), .fill_w(fill_w), .fill_h(fill_h), .partial(partial),
    .remain(remain), .overflow(overflow), .shadow_flat(shadow_flat));

  // {opcode, total length, class}
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {8'h02,5'd3,2'd0}, {8'h20,5'd4,2'd0}, {8'h24,5'd7,2'd0}, {8'h28,5'd5,2'd0},
    {8'h30,5'd6,2'd0}, {8'h38,5'd8,2'd0}, {8'h60,5'd3,2'd0}, {8'h64,5'd4,2'd0},
    {8'h68,5'd2,2'd0}, {8'h6C,5'd1,2'd0}, {8'h74,5'd3,2'd0}, {8'h7C,5'd3,2'd0},
    {8'h00,5'd1,2'd0}, {8'h80,5'd4,2'd1}, {8'h9F,5'd4,2'd1}, {8'hA0,5'd3,2'd2},
    {8'hDF,5'd3,2'd2}, {8'hE1,5'd1,2'd3}, {8'hE7,5'd1,2'd3}, {8'h40,5'd3,2'd0},
    {8'h50,5'd4,2'd0}};

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_word = w;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic take();
    pkt_ready = 1;
    @(negedge clk);
    pkt_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w0;
    string rq;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!pkt_valid && in_ready && !partial && !overflow && shadow_flat == '0, "R10",
        {pkt_valid, in_ready, partial, overflow}, 32'b0100);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op; logic [4:0] ln; logic [1:0] cl;
      op = VEC[v][14:7]; ln = VEC[v][6:2]; cl = VEC[v][1:0];
      rq = (cl == 1) ? "R2" : (cl == 2) ? "R3" : (cl == 3) ? "R4" : "R1";
      w0 = {op, 24'h001000 + 24'(v)};
      push(w0);
      for (int k = 1; k < ln; k++) begin
        chk(partial && !pkt_valid && remain == ln - 5'(k), "R5", {27'd0, remain}, 32'(ln) - 32'(k));
        push(32'hA0000000 + 32'(k));
      end
      chk(pkt_valid && pkt_len == ln, rq, {27'd0, pkt_len}, {27'd0, ln});
      chk(pkt_class == cl, rq, {30'd0, pkt_class}, {30'd0, cl});
      chk(pkt_data[31:0] == w0, "R5", pkt_data[31:0], w0);
      if (ln > 1)
        chk(pkt_data[(ln-1)*32 +: 32] == 32'hA0000000 + 32'(ln) - 1, "R5",
            pkt_data[(ln-1)*32 +: 32], 32'hA0000000 + 32'(ln) - 1);
      if (op[7:4] == 4'hE)
        chk(shadow_flat[op[2:0]*32 +: 32] == w0, "R4", shadow_flat[op[2:0]*32 +: 32], w0);
      take();
    end

    // R9: held packet stays put, input stalled
    push(32'h80000000);
    push(32'h1); push(32'h2); push(32'h3);
    repeat (4) @(negedge clk);
    chk(pkt_valid && !in_ready && pkt_len == 4 && pkt_data[127:96] == 32'h3, "R9",
        {pkt_valid, in_ready}, 32'b10);
    take();
    chk(!pkt_valid && in_ready, "R9", {pkt_valid, in_ready}, 32'b01);

    // R7 fill decode
    push(32'h02000000); push(32'h0); push(32'hFEABFD55);
    chk(pkt_valid && fill_w == 10'h155, "R7", {22'd0, fill_w}, 32'h155);
    chk(fill_h == 9'h0AB, "R7", {23'd0, fill_h}, 32'h0AB);
    take();

    // R6 anomaly
    w0 = shadow_flat[31:0];
    push(32'h1F000000);
    chk(!pkt_valid && !partial && shadow_flat[31:0] == w0, "R6", {pkt_valid, partial}, 32'b00);
    push(32'h00000005);
    chk(pkt_valid && pkt_len == 1 && pkt_data[31:0] == 32'h5, "R6", pkt_data[31:0], 32'h5);
    take();

    // R8 overflow: 12-word packet with DEPTH 8
    push(32'h3C000000);
    chk(overflow && !partial && !pkt_valid, "R8", {overflow, partial, pkt_valid}, 32'b100);
    for (int k = 1; k < 12; k++) push(32'h3C000000 + 32'(k));
    chk(!pkt_valid && !partial, "R8", {pkt_valid, partial}, 32'b00);
    push(32'hE2000077);
    chk(pkt_valid && pkt_class == 3 && overflow, "R8", {pkt_valid, overflow}, 32'b11);
    chk(shadow_flat[95:64] == 32'hE2000077, "R4", shadow_flat[95:64], 32'hE2000077);
    take();

    // R10 reset with partial packet held
    push(32'h20000000); push(32'h1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!partial && !pkt_valid && !overflow && shadow_flat == '0, "R10",
        {partial, pkt_valid, overflow}, 32'b000);

    summary();
    $finish;
  end
endmodule